// File: doc/BRIEF.md
# Up/Down Counter with Output-Compare Channel

This block is a general-purpose timer built around one counter and one output-compare channel. The counter runs in one of two shapes. In edge mode it climbs from zero to the period value and restarts at zero. In center mode it climbs to the period value and then descends back to zero. Each time the counter equals the compare value the block raises a compare event and a sticky flag. The channel output either inverts on every compare event (toggle style) or stays high while the count is below the compare value (PWM style).

The period, compare and repetition values are written to preload copies through a small write/read port. They reach the working copies only on an update event. An update event is a counter boundary reached once the repetition count has run out, or an external counter reset. A one-pulse option holds the counter idle until a trigger input starts a single run. An external clear input forces the output low until the next update.

The main property of the block is that no compare event is lost when the compare value is swapped at a boundary. If the counter equals the old compare value on one clock and the new value on the next, both clocks produce an event. This covers the wrap in edge mode as well as the crest and the valley in center mode.

Top module: `updown_compare_timer`

## Requirements
- R1: After reset the counter, every register read through the port (addresses 0 to 6), `oc_o`, `cc_evt_o`, `upd_evt_o` and `irq_o` are all zero.
- R2: Edge mode. Control address 0 has bit0 = enable, bit1 = center, bit2 = one-pulse and bit3 = PWM. With enable set and center clear, the counter steps 0,1,…,P,0,… where P is the period (address 1). `cc_evt_o` is high on exactly one clock per period when the compare value C (address 2) is at most P, and on none when C > P.
- R3: Center mode (bit1 set). The counter steps 0,1,…,P,P−1,…,1,0,… with one period lasting 2P clocks. `cc_evt_o` is high twice per period for 0 < C < P, once for C = 0 or C = P, and never for C > P.
- R4: Writes to the period, compare and repetition registers (addresses 1 to 3) reach the working copies only on an update event, signalled on `upd_evt_o`. The working copies follow the written values directly while the counter is stopped. A boundary is the wrap in edge mode, or the step into the crest or the step into the valley in center mode. With repetition value N, an update occurs on every (N+1)-th boundary.
- R5: In edge mode, if the compare value is changed from P to 0 before the wrap, events occur on the clock with count P and on the following clock with count 0.
- R6: In center mode, if the compare value is changed from P−1 to P before the crest, events occur on the consecutive clocks with counts P−1 and P. If it is changed from 1 to 0 before the valley, events occur on the consecutive clocks with counts 1 and 0.
- R7: In toggle style (bit3 clear) `oc_o` inverts on the clock after each compare event. It restarts low whenever the counter is stopped. An abrupt compare change as in R5 therefore yields a high pulse exactly one clock wide.
- R8: Status address 4 reads bit0 = compare flag and bit1 = update flag. Both flags are sticky and are cleared by writing 1 to the matching bit at address 5. `irq_o` is high while either flag is set.
- R9: With one-pulse set, the counter is held at 0 until `trig_i` is sampled high. It then runs a single period and stops at the update event. A trigger sampled on the clock where the count equals P starts a new run without a gap.
- R10: In PWM style, `oc_o` is high while the counter runs and its value is below C. A pulse on `clr_i` forces `oc_o` low until the next update event. `ext_rst_i` zeroes the counter and is itself an update event, so the output resumes at once rather than staying low for an extra period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | W | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | W | Register read data (combinational) |
| trig_i | input | 1 | One-pulse start trigger |
| clr_i | input | 1 | External output clear |
| ext_rst_i | input | 1 | External counter reset |
| oc_o | output | 1 | Compare channel output |
| cc_evt_o | output | 1 | Compare event, high on each matching clock |
| upd_evt_o | output | 1 | Update event, high on each update clock |
| irq_o | output | 1 | Interrupt, OR of the sticky flags |

## Verification
The bench builds the block with its default 16-bit counter and 8-bit repetition width. It programs periods of 3 to 9, which puts several whole periods, including both center-mode turning points and several repetition cycles, within a few dozen clocks. These short periods let the bench place compare changes just before the wrap, the crest or the valley and count the back-to-back events that result. They also let it land a trigger exactly on the final count of a one-pulse run, and send an external reset while a clear is still holding the output low.

// File: rtl/updown_compare_timer.sv
module updown_compare_timer #(
  parameter int W  = 16,
  parameter int RW = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [2:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic [2:0]   rd_addr,
  output logic [W-1:0] rd_data,
  input  logic         trig_i,
  input  logic         clr_i,
  input  logic         ext_rst_i,
  output logic         oc_o,
  output logic         cc_evt_o,
  output logic         upd_evt_o,
  output logic         irq_o
);
  localparam logic [2:0] A_CTRL = 3'd0, A_PER = 3'd1, A_CMP = 3'd2, A_REP = 3'd3,
                         A_FLG  = 3'd4, A_CLR = 3'd5, A_CNT = 3'd6;
  localparam logic [W-1:0] ONE = W'(1);

  logic [3:0]    ctrl;
  logic [W-1:0]  arr_p, cmp_p, arr_a, cmp_a, cnt;
  logic [RW-1:0] rep_p, rep_c;
  logic          dn, run_q, tgl_q, clr_q, flg_cc, flg_up;

  wire en  = ctrl[0];
  wire ctr = ctrl[1];
  wire opm = ctrl[2];
  wire pwm = ctrl[3];

  wire active = en & (~opm | run_q);
  wire hit    = active & (cnt == cmp_a);
  wire bnd    = active & (!ctr ? (cnt >= arr_a)
                        : (!dn ? ({1'b0, cnt} + {1'b0, ONE} >= {1'b0, arr_a}) : (cnt <= ONE)));
  wire upd    = active & (ext_rst_i | (bnd & (rep_c == '0)));
  wire clr_wr = wr_en & (wr_addr == A_CLR);

  assign cc_evt_o  = hit;
  assign upd_evt_o = upd;
  assign irq_o     = flg_cc | flg_up;
  assign oc_o      = (pwm ? (active & (cnt < cmp_a)) : tgl_q) & ~clr_q;

  always_comb begin
    case (rd_addr)
      A_CTRL:  rd_data = W'(ctrl);
      A_PER:   rd_data = arr_p;
      A_CMP:   rd_data = cmp_p;
      A_REP:   rd_data = W'(rep_p);
      A_FLG:   rd_data = W'({flg_up, flg_cc});
      A_CNT:   rd_data = cnt;
      default: rd_data = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0; arr_p <= '0; cmp_p <= '0; rep_p <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_CTRL:  ctrl  <= wr_data[3:0];
        A_PER:   arr_p <= wr_data;
        A_CMP:   cmp_p <= wr_data;
        A_REP:   rep_p <= wr_data[RW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; dn <= 1'b0; tgl_q <= 1'b0;
      arr_a <= '0; cmp_a <= '0; rep_c <= '0;
    end else if (!active) begin
      cnt <= '0; dn <= 1'b0; tgl_q <= 1'b0;
      arr_a <= arr_p; cmp_a <= cmp_p; rep_c <= rep_p;
    end else begin
      if (upd) begin
        arr_a <= arr_p; cmp_a <= cmp_p; rep_c <= rep_p;
      end else if (bnd) begin
        rep_c <= rep_c - 1'b1;
      end
      if (ext_rst_i) begin
        cnt <= '0; dn <= 1'b0;
      end else if (!ctr) begin
        cnt <= bnd ? '0 : cnt + ONE;
        dn  <= 1'b0;
      end else if (!dn) begin
        cnt <= cnt + ONE;
        if (bnd) dn <= 1'b1;
      end else begin
        cnt <= cnt - ONE;
        if (bnd) dn <= 1'b0;
      end
      if (hit) tgl_q <= ~tgl_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0; clr_q <= 1'b0; flg_cc <= 1'b0; flg_up <= 1'b0;
    end else begin
      if (!en)              run_q <= 1'b0;
      else if (trig_i)      run_q <= 1'b1;
      else if (opm && upd)  run_q <= 1'b0;

      if (clr_i)                 clr_q <= 1'b1;
      else if (upd || !active)   clr_q <= 1'b0;

      if (hit)                        flg_cc <= 1'b1;
      else if (clr_wr && wr_data[0])  flg_cc <= 1'b0;
      if (upd)                        flg_up <= 1'b1;
      else if (clr_wr && wr_data[1])  flg_up <= 1'b0;
    end
  end

  a_r2_edge_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !ctr && cnt >= arr_a && !ext_rst_i && !wr_en) |=> (cnt == '0));

  a_r5_wrap_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !ctr && !opm && cnt >= arr_a && rep_c == '0 && cmp_p == '0
     && !ext_rst_i && !wr_en) |=> cc_evt_o);

  a_r6_valley_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (active && ctr && dn && !opm && cnt == ONE && rep_c == '0 && cmp_p == '0
     && !ext_rst_i && !wr_en) |=> cc_evt_o);

  a_r7_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !pwm && en && !opm && !wr_en) |=> (tgl_q != $past(tgl_q)));

  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flg_cc && !(clr_wr && wr_data[0])) |=> flg_cc);

  a_r9_single_run: assert property (@(posedge clk) disable iff (!rst_n)
    (en && opm && upd && !trig_i && !wr_en) |=> !run_q);

  a_r10_clear_release: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !opm && pwm && ext_rst_i && !clr_i && !wr_en && cmp_p != '0) |=> oc_o);
endmodule

// File: tb/test_updown_compare_timer.sv
module test_updown_compare_timer;
  localparam int W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [W-1:0] wr_data = '0, rd_data;
  logic trig_i = 1'b0, clr_i = 1'b0, ext_rst_i = 1'b0;
  logic oc_o, cc_evt_o, upd_evt_o, irq_o;

  updown_compare_timer #(.W(W), .RW(8)) i_updown_compare_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .trig_i(trig_i), .clr_i(clr_i),
    .ext_rst_i(ext_rst_i), .oc_o(oc_o), .cc_evt_o(cc_evt_o), .upd_evt_o(upd_evt_o),
    .irq_o(irq_o));

  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int hits, pairs, hi, upds;
  bit mon = 1'b0, prev_hit;

  always @(negedge clk) begin
    #1;
    if (mon) begin
      if (cc_evt_o) begin
        hits++;
        if (prev_hit) pairs++;
      end
      prev_hit = cc_evt_o;
      if (oc_o) hi++;
      if (upd_evt_o) upds++;
    end
  end

  // {center, period, compare, samples, expected events}
  localparam int NV = 8;
  localparam int VEC [NV][5] = '{
    '{0, 9, 4, 30, 3}, '{0, 9, 9, 30, 3}, '{0, 9, 0, 30, 3}, '{0, 9, 12, 30, 0},
    '{1, 6, 3, 36, 6}, '{1, 6, 6, 36, 3}, '{1, 6, 0, 36, 3}, '{1, 6, 7, 36, 0}};

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input int d);
    wr_en = 1'b1; wr_addr = a; wr_data = W'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic mon_clr();
    hits = 0; pairs = 0; hi = 0; upds = 0; prev_hit = 1'b0;
  endtask

  task automatic setup(input int per, input int cmp, input int rep);
    wr(3'd0, 0); wr(3'd1, per); wr(3'd2, cmp); wr(3'd3, rep); wr(3'd5, 3);
    mon_clr(); mon = 1'b1;
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 7; a++) begin
      rd_addr = 3'(a); #1;
      chk($sformatf("R1 reg %0d", a), int'(rd_data), 0);
    end
    chk("R1 outputs", int'({oc_o, cc_evt_o, upd_evt_o, irq_o}), 0);
    rd_addr = 3'd6;
    @(negedge clk);

    // R2 / R3 table of modes and compare positions
    for (int v = 0; v < NV; v++) begin
      setup(VEC[v][1], VEC[v][2], 0);
      wr(3'd0, 1 + 2 * VEC[v][0]);
      repeat (VEC[v][3]) @(negedge clk);
      mon = 1'b0;
      chk($sformatf("%s vec %0d events", VEC[v][0] ? "R3" : "R2", v), hits, VEC[v][4]);
    end

    // R5 + R7 edge wrap step P -> 0
    setup(5, 5, 0);
    wr(3'd0, 1);
    wr(3'd2, 0);
    repeat (7) @(negedge clk);
    mon = 1'b0;
    chk("R5 wrap events", hits, 2);
    chk("R5 wrap back-to-back", pairs, 1);
    chk("R7 one-clock toggle pulse", hi, 1);

    // R8 flags and clearing
    wr(3'd0, 0);
    rd_addr = 3'd4; #1;
    chk("R8 flags set", int'(rd_data), 3);
    chk("R8 irq high", int'(irq_o), 1);
    @(negedge clk);
    wr(3'd5, 1); #1;
    chk("R8 clear compare flag", int'(rd_data), 2);
    @(negedge clk);
    wr(3'd5, 2); #1;
    chk("R8 clear update flag", int'(rd_data), 0);
    chk("R8 irq low", int'(irq_o), 0);
    rd_addr = 3'd6;
    @(negedge clk);

    // R6 crest step P-1 -> P
    setup(8, 7, 0);
    wr(3'd0, 3);
    wr(3'd2, 8);
    repeat (11) @(negedge clk);
    mon = 1'b0;
    chk("R6 crest events", hits, 2);
    chk("R6 crest back-to-back", pairs, 1);
    chk("R7 crest toggle pulse", hi, 1);

    // R6 valley step 1 -> 0, R4 preload held until the valley
    setup(4, 1, 0);
    wr(3'd0, 3);
    repeat (4) @(negedge clk);
    wr(3'd2, 0);
    repeat (7) @(negedge clk);
    mon = 1'b0;
    chk("R6 valley events", hits, 3);
    chk("R6 valley back-to-back", pairs, 1);

    // R4 repetition counter
    setup(3, 9, 2);
    wr(3'd0, 1);
    repeat (24) @(negedge clk);
    mon = 1'b0;
    chk("R4 edge updates every third wrap", upds, 2);
    setup(4, 9, 1);
    wr(3'd0, 3);
    repeat (16) @(negedge clk);
    mon = 1'b0;
    chk("R4 center updates every second boundary", upds, 2);

    // R9 one-pulse
    setup(5, 3, 0);
    wr(3'd0, 13);
    repeat (3) @(negedge clk);
    chk("R9 idle count", int'(rd_data), 0);
    chk("R9 idle output", int'(oc_o), 0);
    mon_clr();
    trig_i = 1'b1; @(negedge clk); trig_i = 1'b0;
    for (int k = 0; k < 20; k++) begin
      if (rd_data == W'(5)) break;
      @(negedge clk);
    end
    trig_i = 1'b1; @(negedge clk); trig_i = 1'b0;
    repeat (12) @(negedge clk);
    mon = 1'b0;
    chk("R9 two back-to-back pulses high clocks", hi, 6);
    chk("R9 events", hits, 2);
    chk("R9 stopped count", int'(rd_data), 0);
    chk("R9 stopped output", int'(oc_o), 0);

    // R10 clear then external reset before compare
    setup(9, 5, 0);
    wr(3'd0, 9);
    chk("R10 output high at start", int'(oc_o), 1);
    clr_i = 1'b1; @(negedge clk); clr_i = 1'b0;
    chk("R10 cleared low", int'(oc_o), 0);
    @(negedge clk);
    chk("R10 still low before compare", int'(oc_o), 0);
    ext_rst_i = 1'b1; @(negedge clk); ext_rst_i = 1'b0;
    chk("R10 count zero after reset", int'(rd_data), 0);
    chk("R10 output restored at once", int'(oc_o), 1);
    mon = 1'b0;

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule